// File: doc/BRIEF.md
# Reduced-Precision Floating-Point Multiplier

This block multiplies two 18-bit floating-point words and returns their product in the same compact format. A word holds a sign bit, then an offset-binary exponent, then an unsigned fraction mantissa. The mantissa has no hidden bit. A normalised value keeps its mantissa in the range [0.5, 1).

The datapath XORs the two signs and multiplies the two 9-bit fractions. It then renormalises the 18-bit product with at most a one-place left shift. The exponent is corrected by the bias, with one extra when the shift was taken. Low product bits are dropped rather than rounded. There are no special values, no rounding and no error reporting. The arithmetic is combinational and feeds one output register, so a product appears one clock after its operands.

The block suits narrow-word DSP datapaths, such as IIR filter sections, where dynamic range matters more than precision.

Top module: `fmul18`

## Requirements
- R1: A word is laid out as bit 17 = sign, bits 16:9 = exponent, bits 8:0 = mantissa. The exponent is offset binary: 128 stands for 2^0, 130 for 2^2 and 126 for 2^-2. The mantissa bit 8 weighs 0.5.
- R2: The result sign (bit 17) is the XOR of the two operand signs, with 0 meaning positive. This holds for every operand pair, including zero operands.
- R3: When bit 17 of the 18-bit mantissa product is 1, the result exponent is exp_a + exp_b - 128 and the result mantissa is product bits 17:9.
- R4: When bit 17 of the mantissa product is 0, the product is shifted left by one place before bits 17:9 are taken, and the result exponent is exp_a + exp_b - 129.
- R5: No rounding is applied. Product bits below the kept nine are discarded, so 0x1FF times 0x1FF yields mantissa 0x1FE.
- R6: If either operand mantissa is zero, the result exponent and mantissa are both zero, and the sign still follows R2.
- R7: The result is registered. Operands present at a rising clock edge appear on `prod_o` after that edge. A synchronous active-high reset clears `prod_o` to zero.
- R8: The exponent arithmetic wraps modulo 256 with no flag, both above the top of the range and below zero.
- R9: When both operands are normalised (mantissa bit 8 set), the result mantissa bit 8 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 18 | First operand word |
| op_b | input | 18 | Second operand word |
| prod_o | output | 18 | Registered product word |

## Verification
The one-place renormalising shift and the silent exponent wraparound can act on the same product. Consider two minimum-magnitude normalised fractions (0.5 × 0.5) with small exponents. The shift is taken, and the extra unit subtracted by the shift pushes the exponent sum below zero. The bench drives that pairing on purpose, along with its mirror case near the top of the exponent range. It also sends a zero mantissa together with a wrapping exponent. Each result is judged as an exact 18-bit word against a behavioural model computed with integers.

// File: rtl/fmul18_pkg.sv
package fmul18_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 9;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int BIAS   = 128;
endpackage

// File: rtl/fmul18_mant.sv
module fmul18_mant #(
  parameter int MAN_W = 9
) (
  input  logic [MAN_W-1:0] man_a,
  input  logic [MAN_W-1:0] man_b,
  output logic [MAN_W-1:0] man_o,
  output logic             shift_o,
  output logic             zero_o
);
  localparam int PW = 2 * MAN_W;

  logic [PW-1:0] full;
  logic [PW-1:0] norm;

  always_comb begin
    full    = {{MAN_W{1'b0}}, man_a} * {{MAN_W{1'b0}}, man_b};
    shift_o = ~full[PW-1];
    norm    = shift_o ? (full << 1) : full;
    man_o   = norm[PW-1 -: MAN_W];
    zero_o  = (man_a == '0) || (man_b == '0);
  end

  // R9: two normalised fractions never leave the leading bit clear
  always_comb begin
    if (man_a[MAN_W-1] && man_b[MAN_W-1])
      assert_norm_out_R9: assert (man_o[MAN_W-1]);
  end
endmodule

// File: rtl/fmul18_exp.sv
module fmul18_exp #(
  parameter int EXP_W = 8,
  parameter int BIAS  = 128
) (
  input  logic [EXP_W-1:0] exp_a,
  input  logic [EXP_W-1:0] exp_b,
  input  logic             shift_i,
  output logic [EXP_W-1:0] exp_o
);
  localparam int SW = EXP_W + 2;

  logic [SW-1:0] acc;

  always_comb begin
    acc = {2'b00, exp_a} + {2'b00, exp_b} - SW'(BIAS)
          - {{(SW-1){1'b0}}, shift_i};
    exp_o = acc[EXP_W-1:0];
  end
endmodule

// File: rtl/fmul18.sv
module fmul18
  import fmul18_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W,
  parameter int BS = BIAS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [EW+MW:0]      op_a,
  input  logic [EW+MW:0]      op_b,
  output logic [EW+MW:0]      prod_o
);
  localparam int WW  = 1 + EW + MW;
  localparam int SGN = WW - 1;

  logic [MW-1:0] man_r;
  logic [EW-1:0] exp_r;
  logic          shift_w, zero_w, sign_w;
  logic [WW-1:0] next_w;
  logic [WW-1:0] prod_q;

  fmul18_mant #(.MAN_W(MW)) u_mant (
    .man_a  (op_a[MW-1:0]),
    .man_b  (op_b[MW-1:0]),
    .man_o  (man_r),
    .shift_o(shift_w),
    .zero_o (zero_w)
  );

  fmul18_exp #(.EXP_W(EW), .BIAS(BS)) u_exp (
    .exp_a  (op_a[MW +: EW]),
    .exp_b  (op_b[MW +: EW]),
    .shift_i(shift_w),
    .exp_o  (exp_r)
  );

  always_comb begin
    sign_w = op_a[SGN] ^ op_b[SGN];
    if (zero_w) next_w = {sign_w, {(EW+MW){1'b0}}};
    else        next_w = {sign_w, exp_r, man_r};
  end

  always_ff @(posedge clk) begin
    if (rst) prod_q <= '0;
    else     prod_q <= next_w;
  end

  assign prod_o = prod_q;

  // R7: reset leaves an all-zero word
  assert_reset_clear_R7: assert property (@(posedge clk)
    $past(rst) |-> prod_q == '0);

  // R2: sign of the registered result follows the operands of the prior edge
  assert_sign_xor_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> prod_q[SGN] == ($past(op_a[SGN]) ^ $past(op_b[SGN])));

  // R6: a zero mantissa on either side clears the magnitude
  assert_zero_mag_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_a[MW-1:0]) == '0 || $past(op_b[MW-1:0]) == '0))
    |-> prod_q[SGN-1:0] == '0);

  // R9: normalised operands give a normalised registered result
  assert_norm_reg_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_a[MW-1]) && $past(op_b[MW-1]))
    |-> prod_q[MW-1]);

  // R3/R4: the exponent lands on one of the two bias choices
  assert_exp_pick_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_a[MW-1:0]) != '0 && $past(op_b[MW-1:0]) != '0)
    |-> (prod_q[MW +: EW] == EW'($past(op_a[MW +: EW]) + $past(op_b[MW +: EW]) - BS)
      || prod_q[MW +: EW] == EW'($past(op_a[MW +: EW]) + $past(op_b[MW +: EW]) - BS - 1)));
endmodule

// File: tb/tb_fmul18.sv
module tb_fmul18;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [17:0] op_a = '0;
  logic [17:0] op_b = '0;
  logic [17:0] prod_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  fmul18 dut (.clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .prod_o(prod_o));

  function automatic logic [17:0] model(input logic [17:0] a, input logic [17:0] b);
    int p, e, m;
    logic s;
    s = a[17] ^ b[17];
    if (a[8:0] == 0 || b[8:0] == 0) return {s, 17'd0};
    p = int'(a[8:0]) * int'(b[8:0]);
    e = int'(a[16:9]) + int'(b[16:9]);
    if (p >= (1 << 17)) begin m = p >> 9;        e = e - 128; end
    else                begin m = (p << 1) >> 9; e = e - 129; end
    e = e & 255;
    return {s, e[7:0], m[8:0]};
  endfunction

  task automatic check(input string tag, input logic [17:0] got, input logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // apply at negedge, check at following negedge (one register)
  task automatic apply(input string tag, input logic [17:0] a, input logic [17:0] b);
    @(negedge clk);
    op_a = a; op_b = b;
    @(negedge clk);
    check(tag, prod_o, model(a, b));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset value", prod_o, 18'd0);
    rst = 1'b0;
    // R1: 0.5*2^1 times itself = 0.25*2^2 -> shift -> 0.5*2^1 = {0,129,0x100}
    apply("R1 field layout", {1'b0, 8'd129, 9'h100}, {1'b0, 8'd129, 9'h100});
    check("R1 explicit word", prod_o, {1'b0, 8'd129, 9'h100});
    apply("R2 sign neg*pos", {1'b1, 8'd130, 9'h180}, {1'b0, 8'd127, 9'h1C0});
    apply("R2 sign neg*neg", {1'b1, 8'd130, 9'h180}, {1'b1, 8'd127, 9'h1C0});
    // R3: 0x1C0*0x1C0 = 0x31000, bit17 set
    apply("R3 no shift", {1'b0, 8'd128, 9'h1C0}, {1'b0, 8'd131, 9'h1C0});
    check("R3 explicit word", prod_o, {1'b0, 8'd131, 9'h188});
    apply("R4 shift path", {1'b0, 8'd140, 9'h101}, {1'b0, 8'd120, 9'h120});
    // R5: 0x1FF^2 = 0x3FC01 -> mantissa 0x1FE
    apply("R5 truncation", {1'b0, 8'd128, 9'h1FF}, {1'b0, 8'd128, 9'h1FF});
    check("R5 explicit word", prod_o, {1'b0, 8'd128, 9'h1FE});
    apply("R6 zero a", {1'b1, 8'd200, 9'h000}, {1'b0, 8'd100, 9'h155});
    check("R6 explicit word", prod_o, {1'b1, 17'd0});
    apply("R6 zero b", {1'b0, 8'd3, 9'h1AA}, {1'b0, 8'd250, 9'h000});
    // R8: 0.5*0.5 with small exponents: 1+1-129 wraps to 129
    apply("R8 wrap low with shift", {1'b0, 8'd1, 9'h100}, {1'b0, 8'd1, 9'h100});
    check("R8 explicit word", prod_o, {1'b0, 8'd129, 9'h100});
    apply("R8 wrap high", {1'b0, 8'd250, 9'h1F0}, {1'b1, 8'd240, 9'h1E0});
    apply("R6 zero with wrap exp", {1'b0, 8'd255, 9'h000}, {1'b0, 8'd255, 9'h1FF});
    for (int i = 0; i < 300; i++) begin
      logic [17:0] a, b;
      a = $urandom; b = $urandom;
      a[8] = 1'b1; b[8] = 1'b1;
      apply("R9 random normalised", a, b);
      checks++;
      if (prod_o[8] !== 1'b1) begin
        fails++;
        $display("FAIL R9 msb got=%b expected=1", prod_o[8]);
      end
    end
    for (int i = 0; i < 200; i++) begin
      logic [17:0] a, b;
      a = $urandom; b = $urandom;
      apply("R3 R4 random any", a, b);
    end
    // back-to-back stream: every clock a new pair, compared each clock
    begin
      logic [17:0] pa, pb;
      @(negedge clk);
      pa = $urandom; pb = $urandom; op_a = pa; op_b = pb;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        check("R7 streaming latency", prod_o, model(pa, pb));
        pa = $urandom; pb = $urandom; op_a = pa; op_b = pb;
      end
    end
    rst = 1'b1;
    @(negedge clk);
    check("R7 reset mid-run", prod_o, 18'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule